// File: doc/BRIEF.md
# Real-Time Clock Timebase Prescaler

This block produces the once-per-second tick that advances the time counters of a real-time clock. It also produces one selectable clock-out signal. It runs entirely on a fast system clock. Two single-cycle enable strobes stand for the edges of the time source. One strobe marks each crystal oscillator cycle and the other marks each cycle of the mains line input.

An 8-bit control register, reached over a simple byte bus, configures the block. It picks the crystal or the line as the source. It names which of four crystal frequencies is fitted, so that the prescaler ratio always yields 1 Hz. It selects 50 or 60 Hz operation for the line, and it picks the clock-out tap. A run bit lets the divider chain count. When the run bit is cleared, the 32 Hz to 1 Hz stages are held at zero, while the faster taps keep running.

The crystal path divides down to 128 Hz. That rate feeds a 7-bit chain whose bits give the 64 Hz to 1 Hz square waves. The line path divides by 25 or 30 and advances the chain in half-second steps. A parameter `PRESCALE_SHIFT` scales the crystal ratios down for short simulations; its default of 0 gives real-time ratios.

Top module: `rtc_timebase`

## Requirements
- R1: After synchronous reset the control byte reads 0 (crystal source, 4.194304 MHz, stopped, clock-out code 0), `tick_1hz` is low and `clk_out` is low.
- R2: A bus write with address 0xB1 stores the byte. A read at address 0x31 returns the stored byte, and any other address, 0xB1 included, reads 0. A write at any other address changes nothing.
- R3: Control layout: bit 7 run, bit 6 line source, bits 5:4 crystal select, bit 3 line rate, bits 2:0 clock-out code. Crystal select 0/1/2/3 means 4194304/2097152/1048576/32768 Hz. With the crystal source and running, one tick is issued every 128 x R crystal strobes, where R = max(1, (F/128) >> PRESCALE_SHIFT).
- R4: With bit 6 set, crystal strobes are ignored, and one tick is issued every 50 line strobes when bit 3 is 1, or every 60 when bit 3 is 0.
- R5: `tick_1hz` is high for exactly one system clock cycle per tick.
- R6: With bit 7 clear, no tick is issued, and the 2 Hz, 1 Hz and 1/60 Hz clock-out taps hold still. The source, source/2, source/4 and 64 Hz taps keep running. Setting bit 7 again resumes ticking at the selected rate.
- R7: A write that changes bit 6, bits 5:4 or bit 3 restarts the prescaler and the chain. With a strobe every cycle, the first tick appears 128 x R + 1 cycles after the write edge.
- R8: Clock-out code 0 gives the source strobe delayed one cycle, code 1 gives a square wave at source/2, and code 2 gives a square wave at source/4.
- R9: Code 3 gives 64 Hz, code 4 gives 2 Hz and code 5 gives 1 Hz square waves, as chain bits 0, 5 and 6. In line mode, the 64 Hz and 2 Hz taps stay low.
- R10: Code 6 gives a square wave that is low for 30 ticks and then high for 30 ticks, and code 7 holds `clk_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_stb | input | 1 | One-cycle strobe per crystal cycle |
| line_stb | input | 1 | One-cycle strobe per mains line cycle |
| bus_addr | input | 8 | Byte bus address |
| bus_wr | input | 1 | Byte bus write enable |
| bus_wdata | input | 8 | Byte bus write data |
| bus_rdata | output | 8 | Byte bus read data (combinational) |
| tick_1hz | output | 1 | One-cycle pulse each second |
| clk_out | output | 1 | Selected clock-out signal |

## Verification
A wrong prescaler ratio or count shows up as a wrong interval between ticks, and the first interval already exposes it. A missed clear on a source change shows up within one second as a first tick at the wrong distance from the write. A chain that keeps counting while stopped shows up as a tick, or as a moving 1 Hz or 2 Hz tap, within one second of the stop. A wrong tap or minute count changes the number of high samples or edges seen in one output period.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;

    localparam logic [7:0] CTRL_RD_ADDR = 8'h31;
    localparam logic [7:0] CTRL_WR_ADDR = 8'hB1;
    localparam int CHAIN_W      = 7;   // 128 Hz input -> 64 Hz .. 1 Hz bits
    localparam int SECS_PER_MIN = 60;
    localparam int MIN_W        = $clog2(SECS_PER_MIN);
    localparam int LINE_HALF_50 = 25;
    localparam int LINE_HALF_60 = 30;

    typedef enum logic [2:0] {
        COUT_SRC  = 3'd0,
        COUT_DIV2 = 3'd1,
        COUT_DIV4 = 3'd2,
        COUT_64HZ = 3'd3,
        COUT_2HZ  = 3'd4,
        COUT_1HZ  = 3'd5,
        COUT_MIN  = 3'd6,
        COUT_OFF  = 3'd7
    } cout_sel_e;

    typedef struct packed {
        logic      run;
        logic      line_src;
        logic [1:0] xtal_sel;
        logic      fifty_hz;
        cout_sel_e cout_sel;
    } ctrl_t;

    // Source strobes per prescaler output pulse.
    function automatic int unsigned pre_ratio(input logic line_src, input logic fifty_hz,
                                              input logic [1:0] xtal_sel, input int unsigned shift);
        int unsigned base;
        int unsigned r;
        if (line_src) begin
            r = fifty_hz ? LINE_HALF_50 : LINE_HALF_60;
        end else begin
            base = (xtal_sel == 2'd3) ? 32'd256 : (32'd32768 >> xtal_sel);
            r    = base >> shift;
            if (r == 0) r = 1;
        end
        return r;
    endfunction

    function automatic int pre_width(input int unsigned shift);
        int unsigned m;
        m = pre_ratio(1'b0, 1'b0, 2'd0, shift);
        if (m < LINE_HALF_60) m = LINE_HALF_60;
        return $clog2(m);
    endfunction

endpackage

// File: rtl/rtc_tb_regs.sv
module rtc_tb_regs
    import rtc_timebase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output ctrl_t      ctrl,
    output logic       clr
);
    logic  wr_hit;
    ctrl_t new_ctrl;

    always_comb begin
        wr_hit   = bus_wr && (bus_addr == CTRL_WR_ADDR);
        new_ctrl = ctrl_t'(bus_wdata);
        clr      = wr_hit && ({new_ctrl.line_src, new_ctrl.xtal_sel, new_ctrl.fifty_hz}
                              != {ctrl.line_src, ctrl.xtal_sel, ctrl.fifty_hz});
        bus_rdata = (bus_addr == CTRL_RD_ADDR) ? 8'(ctrl) : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst)         ctrl <= '0;
        else if (wr_hit) ctrl <= new_ctrl;
    end

    // R2: a write at the write address is visible at the read address next cycle
    assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_hit) && !$past(rst) && bus_addr == CTRL_RD_ADDR) |-> bus_rdata == $past(bus_wdata));

endmodule

// File: rtl/rtc_tb_prescale.sv
module rtc_tb_prescale
    import rtc_timebase_pkg::*;
#(
    parameter int unsigned SHIFT = 0,
    parameter int PRE_W = pre_width(SHIFT)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       line_src,
    input  logic       fifty_hz,
    input  logic [1:0] xtal_sel,
    input  logic       xtal_stb,
    input  logic       line_stb,
    output logic       pre_stb,
    output logic       src_q,
    output logic [1:0] src_div
);
    logic             stb;
    logic [PRE_W-1:0] ratio_m1;
    logic [PRE_W-1:0] cnt_q;

    always_comb begin
        stb      = line_src ? line_stb : xtal_stb;
        ratio_m1 = PRE_W'(pre_ratio(line_src, fifty_hz, xtal_sel, SHIFT) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            pre_stb <= 1'b0;
            src_q   <= 1'b0;
            src_div <= '0;
        end else begin
            src_q   <= stb;
            pre_stb <= 1'b0;
            if (stb) begin
                src_div <= src_div + 2'd1;
                if (cnt_q == ratio_m1) begin
                    cnt_q   <= '0;
                    pre_stb <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + PRE_W'(1);
                end
            end
        end
    end

    // R7: a select change restarts the prescaler
    assert_clear_restart_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0 && !pre_stb));
    // R3: the count never passes the selected ratio
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= ratio_m1);

endmodule

// File: rtl/rtc_tb_divchain.sv
module rtc_tb_divchain
    import rtc_timebase_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               run,
    input  logic               line_src,
    input  logic               pre_stb,
    output logic [CHAIN_W-1:0] chain_q,
    output logic               tick_q,
    output logic               min_hi
);
    localparam int MSB = CHAIN_W - 1;

    logic [CHAIN_W-1:0] held;
    logic [CHAIN_W-1:0] step;
    logic               wrap;
    logic [MIN_W-1:0]   min_cnt;

    always_comb begin
        held = chain_q;
        if (!run) held[MSB:1] = '0;
        step = held + CHAIN_W'(1);
        if (!run) step[MSB:1] = '0;
        wrap = pre_stb && run && !clr &&
               (line_src ? chain_q[MSB] : (chain_q == '1));
        min_hi = (min_cnt >= MIN_W'(SECS_PER_MIN / 2));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            chain_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (pre_stb) begin
                if (line_src) chain_q <= run ? {~chain_q[MSB], {(CHAIN_W-1){1'b0}}} : '0;
                else          chain_q <= step;
            end else begin
                chain_q <= held;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       min_cnt <= '0;
        else if (wrap) min_cnt <= (min_cnt == MIN_W'(SECS_PER_MIN - 1)) ? '0 : min_cnt + MIN_W'(1);
    end

    assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    assert_stop_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick_q);
    assert_tick_wraps_R3: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> chain_q == '0);

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_timebase_pkg::*;
#(
    parameter int unsigned PRESCALE_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xtal_stb,
    input  logic       line_stb,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       tick_1hz,
    output logic       clk_out
);
    ctrl_t              ctrl;
    logic               clr;
    logic               pre_stb;
    logic               src_q;
    logic [1:0]         src_div;
    logic [CHAIN_W-1:0] chain;
    logic               min_hi;

    rtc_tb_regs u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl(ctrl), .clr(clr)
    );

    rtc_tb_prescale #(.SHIFT(PRESCALE_SHIFT)) u_pre (
        .clk(clk), .rst(rst), .clr(clr), .line_src(ctrl.line_src),
        .fifty_hz(ctrl.fifty_hz), .xtal_sel(ctrl.xtal_sel),
        .xtal_stb(xtal_stb), .line_stb(line_stb),
        .pre_stb(pre_stb), .src_q(src_q), .src_div(src_div)
    );

    rtc_tb_divchain u_chain (
        .clk(clk), .rst(rst), .clr(clr), .run(ctrl.run), .line_src(ctrl.line_src),
        .pre_stb(pre_stb), .chain_q(chain), .tick_q(tick_1hz), .min_hi(min_hi)
    );

    always_comb begin
        case (ctrl.cout_sel)
            COUT_SRC:  clk_out = src_q;
            COUT_DIV2: clk_out = src_div[0];
            COUT_DIV4: clk_out = src_div[1];
            COUT_64HZ: clk_out = chain[0];
            COUT_2HZ:  clk_out = chain[CHAIN_W-2];
            COUT_1HZ:  clk_out = chain[CHAIN_W-1];
            COUT_MIN:  clk_out = min_hi;
            default:   clk_out = 1'b0;
        endcase
    end

endmodule

// File: tb/rtc_timebase_tb_top.sv
module rtc_timebase_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       xtal_stb = 1'b0;
    logic       line_stb = 1'b0;
    logic [7:0] addr = 8'h31;
    logic [7:0] wdata = 8'h00;
    logic       wr = 1'b0;
    logic [7:0] rdata;
    logic       tick;
    logic       cko;

    int n_run = 0, n_fail = 0;
    int xtal_per = 0, line_per = 0, xc = 0, lc = 0, cyc = 0;
    bit done = 0;

    rtc_timebase #(.PRESCALE_SHIFT(8)) dut_i (
        .clk(clk), .rst(rst), .xtal_stb(xtal_stb), .line_stb(line_stb),
        .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .tick_1hz(tick), .clk_out(cko)
    );

    always @(negedge clk) begin
        if (xtal_per <= 0) xtal_stb = 1'b0;
        else begin
            xtal_stb = (xc == 0);
            xc = (xc + 1 >= xtal_per) ? 0 : xc + 1;
        end
        if (line_per <= 0) line_stb = 1'b0;
        else begin
            line_stb = (lc == 0);
            lc = (lc + 1 >= line_per) ? 0 : lc + 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 8'h31;
    endtask

    task automatic wait_tick(output int w);
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!tick && w < 40000);
    endtask

    task automatic period(input string tag, output int p);
        int w;
        wait_tick(w);
        @(negedge clk);
        p = 1;
        chk({tag, " R5 single-cycle tick"}, int'(tick), 0);
        while (!tick && p < 40000) begin
            @(negedge clk);
            p++;
        end
    endtask

    task automatic count_changes(input int n, output int c);
        logic prev;
        prev = cko;
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cko !== prev) c++;
            prev = cko;
        end
    endtask

    task automatic count_high(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cko === 1'b1) c++;
        end
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 ctrl readback", int'(rdata), 0);
        chk("R1 tick low", int'(tick), 0);
        chk("R1 clk_out low", int'(cko), 0);

        // R2: register access
        wr_reg(8'hB1, 8'h07);
        @(negedge clk);
        chk("R2 read at 0x31", int'(rdata), 7);
        addr = 8'hB1; #1;
        chk("R2 read at 0xB1 is zero", int'(rdata), 0);
        addr = 8'h31;
        wr_reg(8'h31, 8'h55);
        @(negedge clk);
        chk("R2 write at other address ignored", int'(rdata), 7);

        // R10: code 7 holds low while strobes run
        xtal_per = 1;
        count_high(100, v);
        chk("R10 code 7 low", v, 0);

        // R8: source taps
        wr_reg(8'hB1, 8'h80);
        xtal_per = 3;
        repeat (5) @(negedge clk);
        count_high(30, v);
        chk("R8 code 0 source pulses", v, 10);
        xtal_per = 1;
        wr_reg(8'hB1, 8'h81);
        repeat (3) @(negedge clk);
        count_changes(100, v);
        chk("R8 code 1 source/2", v, 100);
        wr_reg(8'hB1, 8'h82);
        repeat (3) @(negedge clk);
        count_changes(100, v);
        chk("R8 code 2 source/4", v, 50);

        // R3: crystal ratios (shift 8: R = 128, 64, 32, 1)
        wr_reg(8'hB1, 8'h80);
        period("R3 sel0", v);
        chk("R3 sel0 period", v, 16384);
        wr_reg(8'hB1, 8'h90);
        period("R3 sel1", v);
        chk("R3 sel1 period", v, 8192);
        wr_reg(8'hB1, 8'hA0);
        period("R3 sel2", v);
        chk("R3 sel2 period", v, 4096);
        wr_reg(8'hB1, 8'hB0);
        period("R3 sel3", v);
        chk("R3 sel3 period", v, 128);
        xtal_per = 2;
        period("R3 sel3 half-rate", v);
        chk("R3 sel3 period at half strobe rate", v, 256);
        xtal_per = 1;

        // R7: restart on select change
        wr_reg(8'hB1, 8'h80);
        repeat (1000) @(negedge clk);
        wr_reg(8'hB1, 8'hA0);
        wait_tick(v);
        chk("R7 first tick after select change", v, 4097);

        // R9: chain taps at sel3 (chain steps every cycle)
        wr_reg(8'hB1, 8'hB3);
        repeat (3) @(negedge clk);
        count_changes(100, v);
        chk("R9 code 3 64Hz", v, 100);
        wr_reg(8'hB1, 8'hB4);
        count_changes(128, v);
        chk("R9 code 4 2Hz", v, 4);
        wr_reg(8'hB1, 8'hB5);
        count_high(128, v);
        chk("R9 code 5 1Hz", v, 64);

        // R10: minute square wave
        wr_reg(8'hB1, 8'hB6);
        count_high(7680, v);
        chk("R10 code 6 minute duty", v, 3840);

        // R6: stop
        wr_reg(8'hB1, 8'hA3);
        wr_reg(8'hB1, 8'h23);
        repeat (3) @(negedge clk);
        count_changes(640, v);
        chk("R6 64Hz runs while stopped", v, 20);
        v = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (tick) v++;
        end
        chk("R6 no tick while stopped", v, 0);
        wr_reg(8'hB1, 8'h25);
        count_high(300, v);
        chk("R6 1Hz tap still while stopped", v, 0);
        wr_reg(8'hB1, 8'hA5);
        period("R6 resume", v);
        chk("R6 resumed period", v, 4096);

        // R4: line source, crystal strobes ignored
        line_per = 3;
        wr_reg(8'hB1, 8'hC8);
        period("R4 50Hz", v);
        chk("R4 50Hz line period", v, 150);
        wr_reg(8'hB1, 8'hC0);
        period("R4 60Hz", v);
        chk("R4 60Hz line period", v, 180);
        wr_reg(8'hB1, 8'hC3);
        count_high(200, v);
        chk("R9 64Hz tap low in line mode", v, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule